// File: doc/BRIEF.md
# DRAM Controller Operating-State Machine

This block is the state-control core of a DRAM memory controller. Software, or a sequencer standing in for it, issues a 3-bit state command with a valid strobe. The block moves between its stable operating states (init-memory, config, access, low-power) and reports where it is on a 3-bit status output. Every move into config, access or low-power passes through a request state. The block waits in that request state until the memory side, which is stubbed here, returns a one-cycle acknowledge.

The block also gates activity. A host-traffic enable is raised only in access. A refresh enable is raised only while the controller sits on the config/access side and is not entering, inside or leaving low-power. DRAM timing, the PHY and the data path are not part of this block.

Top module: `ddr_op_state`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the status at init-memory (code 0), with `hostEnable` and `refreshEnable` both low.
- R2: The status output uses this encoding: init-memory 0, config 1, config-request 2, access 3, access-request 4, low-power 5, low-power-entry-request 6, low-power-exit-request 7.
- R3: The command codes are init 0, config 1, go 2, sleep 3 and wakeup 4. A valid config command (code 1) in init-memory or in access moves the status to config-request (2) at the next edge. An acknowledge there moves it to config (1).
- R4: A valid go command (code 2) in config moves the status to access-request (4). An acknowledge there moves it to access (3).
- R5: A valid sleep command (code 3) in access moves the status to low-power-entry-request (6). An acknowledge there moves it to low-power (5).
- R6: A valid wakeup command (code 4) in low-power moves the status to low-power-exit-request (7). An acknowledge there moves it to access (3). From low-power the next status is only ever 5 or 7, so config is never reached directly.
- R7: A valid init command (code 0) in config returns the status to init-memory (0) at the next edge, with no request state in between.
- R8: A command that is illegal in the current state, including the unused codes 5 to 7, leaves the status unchanged. So does any command presented with `cmdValid` low.
- R9: A request state holds until `ack` is high at an edge. A command presented in a request state is ignored, even in the same cycle as the acknowledge, and the acknowledge still completes the request.
- R10: `ack` in a stable state (0, 1, 3 or 5) has no effect on the status.
- R11: `hostEnable` is high only in access (3). `refreshEnable` is high exactly in states 1, 2, 3 and 4. Both follow the status in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | The command on `cmd` is presented this cycle |
| cmd | input | 3 | State command code |
| ack | input | 1 | Acknowledge from the memory side that completes a request state |
| stateCode | output | 3 | Current operating state |
| hostEnable | output | 1 | Host traffic allowed |
| refreshEnable | output | 1 | Auto-refresh allowed |

## Verification
A new command and the acknowledge that completes a request can arrive in the same cycle. The acknowledge must then win: the request settles into its target state and the command is dropped, not queued. The bench provokes this on purpose in each request state. Its random traffic also raises `ack` and `cmdValid` together often. A reference model that lets the acknowledge take precedence predicts each next status and both enables, and every cycle is compared against it.

// File: rtl/ddr_op_state_pkg.sv
package ddr_op_state_pkg;

  localparam int STATE_W = 3;
  localparam int CMD_W   = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_INIT_MEM     = 3'd0,
    ST_CONFIG       = 3'd1,
    ST_CFG_REQ      = 3'd2,
    ST_ACCESS       = 3'd3,
    ST_ACC_REQ      = 3'd4,
    ST_LOW_POWER    = 3'd5,
    ST_LP_ENTER_REQ = 3'd6,
    ST_LP_EXIT_REQ  = 3'd7
  } opState_t;

  localparam logic [CMD_W-1:0] CMD_INIT   = 3'd0;
  localparam logic [CMD_W-1:0] CMD_CONFIG = 3'd1;
  localparam logic [CMD_W-1:0] CMD_GO     = 3'd2;
  localparam logic [CMD_W-1:0] CMD_SLEEP  = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WAKEUP = 3'd4;

  // One strobe per kind of state step; at most one is high in a cycle.
  typedef struct packed {
    logic toCfgReq;
    logic toAccReq;
    logic toLpEnter;
    logic toLpExit;
    logic toInit;
    logic settle;
  } stepStrobe_t;

  function automatic logic isRequest(opState_t s);
    return (s == ST_CFG_REQ) || (s == ST_ACC_REQ) ||
           (s == ST_LP_ENTER_REQ) || (s == ST_LP_EXIT_REQ);
  endfunction

endpackage

// File: rtl/ddr_op_state_ctrl.sv
module ddr_op_state_ctrl
  import ddr_op_state_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmd,
  input  logic             ack,
  input  opState_t         curState,
  output stepStrobe_t      strobes
);

  always_comb begin
    strobes = '0;
    unique case (curState)
      ST_INIT_MEM: begin
        if (cmdValid && cmd == CMD_CONFIG) strobes.toCfgReq = 1'b1;
      end
      ST_CONFIG: begin
        if (cmdValid && cmd == CMD_GO)        strobes.toAccReq = 1'b1;
        else if (cmdValid && cmd == CMD_INIT) strobes.toInit   = 1'b1;
      end
      ST_ACCESS: begin
        if (cmdValid && cmd == CMD_CONFIG)     strobes.toCfgReq  = 1'b1;
        else if (cmdValid && cmd == CMD_SLEEP) strobes.toLpEnter = 1'b1;
      end
      ST_LOW_POWER: begin
        if (cmdValid && cmd == CMD_WAKEUP) strobes.toLpExit = 1'b1;
      end
      // request states: only the acknowledge matters, commands are dropped
      default: strobes.settle = ack;
    endcase
  end

  // R8: never more than one step decoded per cycle
  a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

  // R9: a request state decodes no command step
  a_r9_req_no_cmd: assert property (@(posedge clk) disable iff (rst)
    isRequest(curState) |-> !(strobes.toCfgReq || strobes.toAccReq ||
                              strobes.toLpEnter || strobes.toLpExit || strobes.toInit));

endmodule

// File: rtl/ddr_op_state_path.sv
module ddr_op_state_path
  import ddr_op_state_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  stepStrobe_t strobes,
  output opState_t    curState,
  output logic        hostEnable,
  output logic        refreshEnable
);

  opState_t nextState;

  always_comb begin
    nextState = curState;
    if (strobes.toCfgReq)       nextState = ST_CFG_REQ;
    else if (strobes.toAccReq)  nextState = ST_ACC_REQ;
    else if (strobes.toLpEnter) nextState = ST_LP_ENTER_REQ;
    else if (strobes.toLpExit)  nextState = ST_LP_EXIT_REQ;
    else if (strobes.toInit)    nextState = ST_INIT_MEM;
    else if (strobes.settle) begin
      unique case (curState)
        ST_CFG_REQ:      nextState = ST_CONFIG;
        ST_ACC_REQ:      nextState = ST_ACCESS;
        ST_LP_ENTER_REQ: nextState = ST_LOW_POWER;
        ST_LP_EXIT_REQ:  nextState = ST_ACCESS;
        default:         nextState = curState;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_INIT_MEM;
    else     curState <= nextState;
  end

  always_comb begin
    hostEnable    = (curState == ST_ACCESS);
    refreshEnable = (curState == ST_CONFIG) || (curState == ST_CFG_REQ) ||
                    (curState == ST_ACCESS) || (curState == ST_ACC_REQ);
  end

  // R9: a settle strobe always leaves the request state
  a_r9_settle_moves: assert property (@(posedge clk) disable iff (rst)
    strobes.settle |=> !isRequest(curState));

  // R6: low-power exit request only ever lands in access
  a_r6_exit_to_access: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_LP_EXIT_REQ && strobes.settle) |=> curState == ST_ACCESS);

endmodule

// File: rtl/ddr_op_state.sv
module ddr_op_state
  import ddr_op_state_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmd,
  input  logic             ack,
  output logic [STATE_W-1:0] stateCode,
  output logic             hostEnable,
  output logic             refreshEnable
);

  opState_t    curState;
  stepStrobe_t strobes;

  ddr_op_state_ctrl ctrl_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmd(cmd), .ack(ack),
    .curState(curState), .strobes(strobes)
  );

  ddr_op_state_path path_i (
    .clk(clk), .rst(rst), .strobes(strobes), .curState(curState),
    .hostEnable(hostEnable), .refreshEnable(refreshEnable)
  );

  assign stateCode = curState;

  // R1: reset lands in init-memory with both gates closed
  a_r1_reset_init: assert property (@(posedge clk)
    rst |=> (stateCode == 3'd0 && !hostEnable && !refreshEnable));

  // R9: request state without acknowledge holds
  a_r9_req_holds: assert property (@(posedge clk) disable iff (rst)
    (isRequest(opState_t'(stateCode)) && !ack) |=> $stable(stateCode));

  // R10: a stable state with no command ignores ack
  a_r10_ack_ignored: assert property (@(posedge clk) disable iff (rst)
    (!isRequest(opState_t'(stateCode)) && !cmdValid) |=> $stable(stateCode));

  // R6: low-power never goes straight to config
  a_r6_lp_no_config: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 3'd5) |=> (stateCode == 3'd5 || stateCode == 3'd7));

  // R11: host traffic implies refresh permitted
  a_r11_host_implies_refresh: assert property (@(posedge clk) disable iff (rst)
    hostEnable |-> refreshEnable);

endmodule

// File: tb/ddr_op_state_tb_top.sv
`timescale 1ns/1ps
module ddr_op_state_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic       ack = 1'b0;
  logic [2:0] stateCode;
  logic       hostEnable, refreshEnable;

  int testsRun = 0;
  int testsFailed = 0;
  logic [2:0] model = 3'd0;

  always #2.5 clk = ~clk;

  ddr_op_state dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmd(cmd), .ack(ack),
    .stateCode(stateCode), .hostEnable(hostEnable), .refreshEnable(refreshEnable)
  );

  function automatic bit reqState(logic [2:0] s);
    return s == 3'd2 || s == 3'd4 || s == 3'd6 || s == 3'd7;
  endfunction

  function automatic logic [2:0] refNext(logic [2:0] s, logic v, logic [2:0] c, logic a);
    if (reqState(s)) begin
      if (!a) return s;
      case (s)
        3'd2: return 3'd1;
        3'd4: return 3'd3;
        3'd6: return 3'd5;
        default: return 3'd3;
      endcase
    end
    if (!v) return s;
    case (s)
      3'd0: return (c == 3'd1) ? 3'd2 : s;
      3'd1: return (c == 3'd2) ? 3'd4 : (c == 3'd0) ? 3'd0 : s;
      3'd3: return (c == 3'd1) ? 3'd2 : (c == 3'd3) ? 3'd6 : s;
      3'd5: return (c == 3'd4) ? 3'd7 : s;
      default: return s;
    endcase
  endfunction

  function automatic string tagOf(logic r, logic [2:0] s, logic v, logic [2:0] c, logic a);
    logic [2:0] n;
    if (r) return "R1";
    if (reqState(s)) return "R9";
    n = refNext(s, v, c, a);
    if (n == s) return (a && !v) ? "R10" : "R8";
    case (c)
      3'd0: return "R7";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // one cycle: drive at negedge, check at next negedge
  task automatic step(logic r, logic v, logic [2:0] c, logic a);
    string tag;
    logic [2:0] exp;
    logic expHost, expRef;
    tag = tagOf(r, model, v, c, a);
    exp = r ? 3'd0 : refNext(model, v, c, a);
    rst = r; cmdValid = v; cmd = c; ack = a;
    @(negedge clk);
    expHost = (exp == 3'd3);                                  // R11
    expRef  = (exp == 3'd1 || exp == 3'd2 || exp == 3'd3 || exp == 3'd4);
    testsRun++;
    if (stateCode !== exp || hostEnable !== expHost || refreshEnable !== expRef) begin
      testsFailed++;
      $display("FAIL %s/R11: state=%0d host=%0b ref=%0b expected state=%0d host=%0b ref=%0b",
               tag, stateCode, hostEnable, refreshEnable, exp, expHost, expRef);
    end
    model = exp;
  endtask

  initial begin
    #200000;
    testsFailed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(1, 0, 3'd0, 0);            // R1 reset
    // R2 walk of the encoding through every state
    step(0, 1, 3'd1, 0);            // R3 init -> 2
    step(0, 0, 3'd0, 0);            // R9 hold
    step(0, 1, 3'd2, 1);            // R9 ack wins, cmd dropped -> 1
    step(0, 0, 3'd0, 1);            // R10 ack in config ignored
    step(0, 1, 3'd0, 0);            // R7 config -> init
    step(0, 1, 3'd1, 0);            // R3
    step(0, 0, 3'd0, 1);            // -> config
    step(0, 1, 3'd2, 0);            // R4 -> 4
    step(0, 0, 3'd0, 1);            // -> 3
    step(0, 1, 3'd6, 0);            // R8 unused code
    step(0, 0, 3'd3, 0);            // R8 valid low
    step(0, 1, 3'd3, 0);            // R5 -> 6
    step(0, 1, 3'd1, 1);            // R9 -> 5
    step(0, 1, 3'd1, 0);            // R6 config illegal in low-power
    step(0, 1, 3'd4, 0);            // R6 -> 7
    step(0, 1, 3'd3, 1);            // R9 -> 3
    step(0, 1, 3'd1, 0);            // R3 access -> 2
    step(0, 0, 3'd0, 1);            // -> 1
    step(0, 1, 3'd2, 0);
    step(0, 0, 3'd0, 1);            // access
    step(0, 1, 3'd3, 0);
    step(0, 0, 3'd0, 1);            // low-power
    step(1, 1, 3'd4, 1);            // R1 reset overrides
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 250) == 0, $urandom % 2, 3'($urandom % 8), ($urandom % 3) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule